// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Controller

This block sits on the host side of a 12-bit serial analog-to-digital converter that is paced by a conversion strobe. When the host requests a sample, the controller drives the strobe high, holds it for a configurable number of system clocks while the converter works, and then drops it. Dropping the strobe makes the converter enable its serial data pin. The controller then produces a serial clock from a clock-enable and shifts the result in most significant bit first. It presents the finished 12-bit code together with a one-cycle completion pulse.

The converter sets each data bit after a falling serial-clock edge. The controller samples that bit at the rising edge that follows. Once the result has been sent, the converter keeps sending zeros for as long as clocking continues. The controller can add a configurable number of trailing serial clocks to each frame, and it discards the bits taken on them. A new request is taken only while the controller is idle. Codes run from 0x000, for equal inputs, to 0xFFF, for full scale.

Top module: `sadc_ctrl`

## Requirements
- R1: After reset, `adc_conv`, `adc_sck`, `busy` and `done` are low and `data` is zero.
- R2: A `start` seen high at a clock edge while idle raises `adc_conv` and `busy` together at that edge.
- R3: `adc_conv` stays high for exactly CONV_CYC system clocks and then falls, and `adc_sck` stays low the whole time `adc_conv` is high.
- R4: `adc_sck` idles low. Its first rising edge comes HALF_CYC clocks after `adc_conv` falls, and every later high or low phase within a frame lasts HALF_CYC clocks.
- R5: `adc_sdo` is sampled on each rising `adc_sck` edge, most significant bit first. After a frame, `data` equals the 12-bit code the converter sent.
- R6: Each frame has exactly DATA_W+TAIL_CLKS rising `adc_sck` edges. Bits seen on the edges after the DATA_W-th do not change `data`, even though the converter sends zeros on them.
- R7: `done` is high for exactly one clock, at the edge where `adc_sck` returns low after the last rising edge. `busy` falls at that same edge. `data` changes only at that edge and holds its value until the next `done`.
- R8: A `start` that arrives while `busy` is high is ignored. It starts no extra conversion and does not disturb the frame in progress.
- R9: A `start` seen in the same cycle as `done` is accepted, and `adc_conv` rises at the next edge.
- R10: The extreme codes 0x000 and 0xFFF are read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request for one conversion, level sampled while idle |
| busy | output | 1 | High from the rising edge of the strobe until completion |
| done | output | 1 | One-cycle pulse when `data` is updated |
| data | output | DATA_W | Last code read from the converter |
| adc_conv | output | 1 | Conversion strobe to the converter |
| adc_sck | output | 1 | Serial clock to the converter, idles low |
| adc_sdo | input | 1 | Serial data from the converter |

## Verification
Two events can fall in the same cycle: a new request and the end of the previous frame. If `start` is high in the cycle where `done` pulses, the sequencer has already returned to idle and must take the request. If `start` is high one cycle earlier, during the final serial-clock phase, the request must be dropped. The bench provokes the first case by raising `start` in the very cycle it observes `done`. It judges the result by checking that `adc_conv` is high in the following cycle and that the new frame returns its own code. Requests pulsed during the strobe phase and the shift phase must leave the line quiet after completion.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // Sequencer phase of one conversion-and-readout frame.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_XFER = 2'd2
  } sadc_phase_e;

endpackage

// File: rtl/sadc_tick.sv
// Half-period clock-enable for the serial clock. It counts only while run is high.
module sadc_tick #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned HW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam logic [HW-1:0] H_LAST = HW'(HALF_CYC - 1);

  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == H_LAST);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sadc_shift.sv
// Capture shift register plus the held result register.
module sadc_shift #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              sdo,
  input  logic              load,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    sh_d   = cap_en ? {sh_q[DATA_W-2:0], sdo} : sh_q;
    word_d = load ? sh_q : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_q <= '0;
    end else begin
      sh_q   <= sh_d;
      word_q <= word_d;
    end
  end

  assign word = word_q;
endmodule

// File: rtl/sadc_seq.sv
// Frame sequencer: strobe timing, serial clock and edge counting, handshake.
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned CONV_CYC  = 40,
  parameter int unsigned TAIL_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic run,
  output logic conv,
  output logic sck,
  output logic busy,
  output logic done,
  output logic cap_en,
  output logic load
);
  localparam int unsigned NCLK = DATA_W + TAIL_CLKS;
  localparam int unsigned CW   = (CONV_CYC < 2) ? 1 : $clog2(CONV_CYC);
  localparam int unsigned EW   = $clog2(NCLK + 1);
  localparam logic [CW-1:0] C_LAST = CW'(CONV_CYC - 1);
  localparam logic [EW-1:0] E_DATA = EW'(DATA_W);
  localparam logic [EW-1:0] E_ALL  = EW'(NCLK);

  sadc_phase_e ph_q, ph_d;
  logic [CW-1:0] ccnt_q, ccnt_d;
  logic [EW-1:0] edg_q, edg_d;
  logic conv_q, conv_d, sck_q, sck_d, busy_q, busy_d, done_q, done_d;
  logic rise, fall, fin;

  always_comb begin
    rise   = (ph_q == PH_XFER) && tick && !sck_q;
    fall   = (ph_q == PH_XFER) && tick && sck_q;
    fin    = fall && (edg_q == E_ALL);
    cap_en = rise && (edg_q < E_DATA);

    ph_d   = ph_q;
    ccnt_d = ccnt_q;
    edg_d  = edg_q;
    conv_d = conv_q;
    sck_d  = sck_q;
    busy_d = busy_q;
    done_d = 1'b0;

    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_CONV;
          conv_d = 1'b1;
          busy_d = 1'b1;
          ccnt_d = '0;
        end
      end
      PH_CONV: begin
        if (ccnt_q == C_LAST) begin
          ph_d   = PH_XFER;
          conv_d = 1'b0;
          edg_d  = '0;
          sck_d  = 1'b0;
        end else begin
          ccnt_d = ccnt_q + CW'(1);
        end
      end
      PH_XFER: begin
        if (rise) begin
          sck_d = 1'b1;
          edg_d = edg_q + EW'(1);
        end
        if (fall) begin
          sck_d = 1'b0;
          if (fin) begin
            ph_d   = PH_IDLE;
            busy_d = 1'b0;
            done_d = 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      ccnt_q <= '0;
      edg_q  <= '0;
      conv_q <= 1'b0;
      sck_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      ccnt_q <= ccnt_d;
      edg_q  <= edg_d;
      conv_q <= conv_d;
      sck_q  <= sck_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign run  = (ph_q == PH_XFER);
  assign conv = conv_q;
  assign sck  = sck_q;
  assign busy = busy_q;
  assign done = done_q;
  assign load = fin;
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned CONV_CYC  = 40,
  parameter int unsigned HALF_CYC  = 2,
  parameter int unsigned TAIL_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              adc_conv,
  output logic              adc_sck,
  input  logic              adc_sdo
);
  logic run, tick, cap_en, load;

  sadc_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  sadc_seq #(
    .DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .TAIL_CLKS(TAIL_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .run(run),
    .conv(adc_conv), .sck(adc_sck), .busy(busy), .done(done),
    .cap_en(cap_en), .load(load)
  );

  sadc_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .sdo(adc_sdo),
    .load(load), .word(data)
  );
endmodule

// File: rtl/sadc_ctrl_chk.sv
module sadc_ctrl_chk #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned CONV_CYC = 40,
  parameter int unsigned HALF_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] data,
  input logic              adc_conv,
  input logic              adc_sck
);
  int unsigned conv_run, sck_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_run <= 0;
      sck_run  <= 0;
    end else begin
      conv_run <= adc_conv ? conv_run + 1 : 0;
      sck_run  <= adc_sck ? sck_run + 1 : 0;
    end
  end

  p_conv_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> busy && $rose(busy));
  p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv) |-> conv_run == CONV_CYC);
  p_no_sck_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> !adc_sck);
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !adc_sck);
  p_sck_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sck) |-> sck_run == HALF_CYC);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data) |-> done);
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> !$past(busy));
endmodule

bind sadc_ctrl sadc_ctrl_chk #(
  .DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .HALF_CYC(HALF_CYC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .data(data),
  .adc_conv(adc_conv), .adc_sck(adc_sck)
);

// File: tb/test_sadc_ctrl.sv
module test_sadc_ctrl;
  localparam int DATA_W = 12, CONV_CYC = 40, HALF_CYC = 2, TAIL_CLKS = 2;

  logic clk = 1'b0;
  logic rst_n, start;
  logic busy, done, adc_conv, adc_sck, adc_sdo;
  logic [DATA_W-1:0] data;
  int n_tests = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  sadc_ctrl #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .HALF_CYC(HALF_CYC),
              .TAIL_CLKS(TAIL_CLKS)) i_sadc_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .data(data), .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sdo(adc_sdo));

  // Converter serial output model: MSB on strobe fall, next bit per falling
  // serial clock, zeros once the word is exhausted.
  logic [DATA_W-1:0] model_code = '0;
  int model_idx = 0;
  always @(negedge adc_conv) begin
    model_idx = 0;
    adc_sdo = model_code[DATA_W-1];
  end
  always @(negedge adc_sck) if (!adc_conv) begin
    model_idx++;
    adc_sdo = (model_idx < DATA_W) ? model_code[DATA_W-1-model_idx] : 1'b0;
  end

  // Port monitor, sampled on the falling clock edge.
  logic conv_p = 1'b0, sck_p = 1'b0;
  int conv_len = 0, rises = 0, gap = -1, fall_at = 0, run = 0, half_err = 0, sck_in_conv = 0;
  always @(negedge clk) begin
    cyc++;
    if (adc_conv && !conv_p) begin
      conv_len = 0; rises = 0; gap = -1; half_err = 0; sck_in_conv = 0;
    end
    if (adc_conv) conv_len++;
    if (adc_conv && adc_sck) sck_in_conv++;
    if (!adc_conv && conv_p) fall_at = cyc;
    if (adc_sck != sck_p) begin
      if (adc_sck) begin
        rises++;
        if (rises == 1) gap = cyc - fall_at;
      end
      if (!(adc_sck && rises == 1) && run != HALF_CYC) half_err++;
      run = 1;
    end else run++;
    conv_p = adc_conv;
    sck_p  = adc_sck;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int lim = 0;
    while (!done && lim < 3000) begin @(negedge clk); lim++; end
    chk(done, "R7 done seen", int'(done), 1);
  endtask

  task automatic frame_checks(input logic [DATA_W-1:0] code);
    chk(data == code, "R5 captured word", int'(data), int'(code));
    chk(!busy, "R7 busy low with done", int'(busy), 0);
    chk(conv_len == CONV_CYC, "R3 strobe width", conv_len, CONV_CYC);
    chk(sck_in_conv == 0, "R3 no sck during strobe", sck_in_conv, 0);
    chk(gap == HALF_CYC, "R4 first rise delay", gap, HALF_CYC);
    chk(half_err == 0, "R4 half period", half_err, 0);
    chk(rises == DATA_W + TAIL_CLKS, "R6 edges per frame", rises, DATA_W + TAIL_CLKS);
    @(negedge clk);
    chk(!done, "R7 done single cycle", int'(done), 0);
  endtask

  task automatic run_conv(input logic [DATA_W-1:0] code, input string tag);
    logic [DATA_W-1:0] prev;
    prev = data;
    model_code = code;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(adc_conv && busy, "R2 strobe and busy rise", int'({adc_conv, busy}), 3);
    @(negedge clk);
    chk(data == prev, "R7 data held", int'(data), int'(prev));
    wait_done();
    chk(data == code, tag, int'(data), int'(code));
    frame_checks(code);
  endtask

  initial begin
    void'($urandom(32'h5ADC));
    rst_n = 1'b0; start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!adc_conv && !adc_sck && !busy && !done, "R1 reset outputs",
        int'({adc_conv, adc_sck, busy, done}), 0);
    chk(data == '0, "R1 reset data", int'(data), 0);

    run_conv(12'h000, "R10 zero code");
    run_conv(12'hFFF, "R10 full-scale code R6");
    run_conv(12'hA5C, "R5 pattern");
    run_conv(12'h801, "R5 msb and lsb");

    // R8: requests during the strobe and the shift phase are dropped.
    model_code = 12'h3C7;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!adc_sck) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    chk(data == 12'h3C7, "R8 frame undisturbed", int'(data), 12'h3C7);
    repeat (6) begin
      @(negedge clk);
      chk(!adc_conv && !busy, "R8 no extra conversion", int'({adc_conv, busy}), 0);
    end

    // R9: request in the done cycle is accepted.
    model_code = 12'h6E1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    chk(data == 12'h6E1, "R9 first frame", int'(data), 12'h6E1);
    model_code = 12'h19B;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(adc_conv && busy, "R9 back-to-back start", int'({adc_conv, busy}), 3);
    wait_done();
    chk(data == 12'h19B, "R9 second frame", int'(data), 12'h19B);

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      run_conv(DATA_W'($urandom), "R5 random code");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule